// File: doc/BRIEF.md
# GPIO Controller with Edge Capture

This block manages seven general-purpose pins behind a small register bus. Software picks the direction of each pin. It also picks, per input pin, whether the pin reports its current level or latches a rising edge. A single status register serves both directions. For an input it returns the synchronized level or the latched edge flag. For an output it holds and returns the level being driven. Latched edge flags clear when software reads that status register.

Per-pin mask bits gate the input status bits onto one registered interrupt line. A read-only interrupt status register shows which pins are currently asserting the interrupt. Reading the interrupt status register never disturbs the status bits, so software reads it to find the cause and then reads the status register to acknowledge.

The register map is: interrupt status 0x2A, direction 0x2C, mask 0x2D, level/edge select 0x2E, status 0x2F. A read returns data on `bus_rdata` from the clock edge that samples `bus_rd`. The value holds until the next read.

Top module: `gpio_edge_ctl`

## Requirements
- R1: After reset, the direction, mask, select and status registers read 0x00, the interrupt status register reads 0x00, `pin_oe` is 0 and `irq` is 0.
- R2: Bit 7 of every register reads 0, even after 0xFF is written. In the select register, bits 6..0 are kept as written.
- R3: With its select bit at 0, an input pin's status bit equals the pin level, delayed by a two-flop synchronizer and one status flop. A read does not clear it.
- R4: With its select bit at 1, a rising edge on an input pin sets the pin's status bit, and a following falling edge leaves it set. A read of 0x2F returns 1 for that bit and clears it, so the next read returns 0.
- R5: If a rising edge is detected in the same cycle as a clearing read of 0x2F, the status bit stays set and the next read still returns 1.
- R6: Status bits latch and clear in the same way whether their mask bit is 0 or 1.
- R7: `irq` is the registered OR, over input pins, of status AND mask. Register 0x2A returns status AND mask AND input per bit. Reading 0x2A clears nothing, and `irq` stays high until 0x2F is read.
- R8: For a masked level-sensitive input, `irq` goes high while the pin is high and goes low after the pin returns low.
- R9: A direction bit of 1 makes the pin an output. `pin_oe` follows the direction bits, and writing 0x2F drives `pin_out` of each output pin to the written bit, which a read of 0x2F returns. For an output pin, the select bit, the `pin_in` level and the mask have no effect.
- R10: Writing 0x2F changes neither the status bit nor `pin_out` of an input pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 7 | Asynchronous pin inputs |
| pin_out | output | 7 | Output drive levels |
| pin_oe | output | 7 | Output enables (1 = driving) |
| irq | output | 1 | Interrupt request, active high |

## Verification
The status register is exercised with four input patterns:
- a level held high and then low on a level-sensitive pin, which separates live reporting from latching;
- a full high-low pulse on an edge pin, which shows that the falling edge does not clear the latch;
- a rising edge timed onto the exact cycle of a clearing read, which shows whether set wins over clear;
- toggles on `pin_in` of output pins, which show that input activity cannot reach an output's status bit.

The interrupt path is driven with masks on edge pins, level pins and output pins. This separates the acknowledge read of 0x2F from the cause read of 0x2A, and shows that output pins never raise `irq`.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam logic [7:0] ADR_IRQ  = 8'h2A;
  localparam logic [7:0] ADR_DIR  = 8'h2C;
  localparam logic [7:0] ADR_MASK = 8'h2D;
  localparam logic [7:0] ADR_SEL  = 8'h2E;
  localparam logic [7:0] ADR_STAT = 8'h2F;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) chain[k] <= '0;
    end else begin
      chain[0] <= d;
      for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell (
  input  logic clk,
  input  logic rst,
  input  logic is_out,
  input  logic edge_mode,
  input  logic lvl,
  input  logic wr_stat,
  input  logic wbit,
  input  logic rd_stat,
  output logic stat,
  output logic drv
);
  logic prev_q, stat_q, drv_q;
  logic rise, drv_n, stat_n;

  assign rise = lvl & ~prev_q;

  always_comb begin
    drv_n = (is_out && wr_stat) ? wbit : drv_q;
    if (is_out)         stat_n = drv_n;
    else if (edge_mode) stat_n = rise | (stat_q & ~rd_stat);
    else                stat_n = lvl;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      stat_q <= 1'b0;
      drv_q  <= 1'b0;
    end else begin
      prev_q <= lvl;
      stat_q <= stat_n;
      drv_q  <= drv_n;
    end
  end

  assign stat = stat_q;
  assign drv  = drv_q;
endmodule

// File: rtl/gpio_edge_ctl.sv
module gpio_edge_ctl #(
  parameter int NPINS = 7,
  parameter int DW    = 8,
  parameter int AW    = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [AW-1:0] A_IRQ  = gpio_pkg::ADR_IRQ,
  parameter logic [AW-1:0] A_DIR  = gpio_pkg::ADR_DIR,
  parameter logic [AW-1:0] A_MASK = gpio_pkg::ADR_MASK,
  parameter logic [AW-1:0] A_SEL  = gpio_pkg::ADR_SEL,
  parameter logic [AW-1:0] A_STAT = gpio_pkg::ADR_STAT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic [DW-1:0]    bus_wdata,
  input  logic             bus_rd,
  output logic [DW-1:0]    bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             irq
);
  localparam int PAD = DW - NPINS;

  logic [NPINS-1:0] dir_q, sel_q, mask_q, stat_q, lvl, drv, pend;
  logic [DW-1:0]    rdata_q;
  logic             irq_q, rd_stat, wr_stat;
  logic             unused_wbits;

  assign unused_wbits = ^bus_wdata[DW-1:NPINS];
  assign rd_stat = bus_rd && (bus_addr == A_STAT);
  assign wr_stat = bus_wr && (bus_addr == A_STAT);
  assign pend    = stat_q & mask_q & ~dir_q;

  gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(lvl)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    gpio_pin_cell i_cell (
      .clk(clk), .rst(rst),
      .is_out(dir_q[i]), .edge_mode(sel_q[i]), .lvl(lvl[i]),
      .wr_stat(wr_stat), .wbit(bus_wdata[i]), .rd_stat(rd_stat),
      .stat(stat_q[i]), .drv(drv[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '0;
      sel_q  <= '0;
      mask_q <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_DIR)  dir_q  <= bus_wdata[NPINS-1:0];
      if (bus_addr == A_SEL)  sel_q  <= bus_wdata[NPINS-1:0];
      if (bus_addr == A_MASK) mask_q <= bus_wdata[NPINS-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= |pend;
      if (bus_rd) begin
        case (bus_addr)
          A_IRQ:   rdata_q <= {{PAD{1'b0}}, pend};
          A_DIR:   rdata_q <= {{PAD{1'b0}}, dir_q};
          A_MASK:  rdata_q <= {{PAD{1'b0}}, mask_q};
          A_SEL:   rdata_q <= {{PAD{1'b0}}, sel_q};
          A_STAT:  rdata_q <= {{PAD{1'b0}}, stat_q};
          default: rdata_q <= '0;
        endcase
      end
    end
  end

  assign bus_rdata = rdata_q;
  assign pin_out   = drv;
  assign pin_oe    = dir_q;
  assign irq       = irq_q;
endmodule

// File: rtl/gpio_edge_ctl_chk.sv
module gpio_edge_ctl_chk #(
  parameter int NPINS = 7,
  parameter int DW    = 8,
  parameter int AW    = 8,
  parameter logic [AW-1:0] A_DIR  = gpio_pkg::ADR_DIR,
  parameter logic [AW-1:0] A_STAT = gpio_pkg::ADR_STAT
) (
  input logic             clk,
  input logic             rst,
  input logic [AW-1:0]    bus_addr,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [DW-1:0]    bus_wdata,
  input logic [DW-1:0]    bus_rdata,
  input logic [NPINS-1:0] pin_out,
  input logic [NPINS-1:0] pin_oe,
  input logic             irq,
  input logic [NPINS-1:0] stat_q,
  input logic [NPINS-1:0] sel_q,
  input logic [NPINS-1:0] dir_q,
  input logic [NPINS-1:0] mask_q
);
  // R2: reserved upper bits read zero
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[DW-1:NPINS] == '0);

  // R4: latched edge bits hold unless the status register is read
  p_edge_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_addr == A_STAT) |=>
      (($past(stat_q & sel_q & ~dir_q) & ~stat_q) == '0));

  // R7: no mask bit set means no interrupt on the next cycle
  p_irq_masked_r7: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |=> !irq);

  // R9: output enables take the written direction value
  p_oe_dir_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_DIR) |=> (pin_oe == $past(bus_wdata[NPINS-1:0])));

  // R10: a status write drives only output pins
  p_out_drive_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_STAT) |=>
      ((((pin_out ^ $past(pin_out)) & ~$past(dir_q)) == '0) &&
       ((pin_out & $past(dir_q)) == ($past(bus_wdata[NPINS-1:0]) & $past(dir_q)))));
endmodule

bind gpio_edge_ctl gpio_edge_ctl_chk #(
  .NPINS(NPINS), .DW(DW), .AW(AW), .A_DIR(A_DIR), .A_STAT(A_STAT)
) i_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_out(pin_out),
  .pin_oe(pin_oe), .irq(irq), .stat_q(stat_q), .sel_q(sel_q),
  .dir_q(dir_q), .mask_q(mask_q)
);

// File: tb/test_gpio_edge_ctl.sv
module test_gpio_edge_ctl;
  localparam logic [7:0] AI = 8'h2A, AD = 8'h2C, AM = 8'h2D, AS = 8'h2E, AT = 8'h2F;

  logic       clk = 1'b0, rst = 1'b1;
  logic [7:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, irq;
  logic [6:0] pin_in = '0, pin_out, pin_oe;
  int checks = 0, errors = 0;

  gpio_edge_ctl i_gpio_edge_ctl (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(AD, d); chk("R1 dir", d, 8'h00);
    rd(AM, d); chk("R1 mask", d, 8'h00);
    rd(AS, d); chk("R1 sel", d, 8'h00);
    rd(AT, d); chk("R1 stat", d, 8'h00);
    rd(AI, d); chk("R1 irqstat", d, 8'h00);
    chk("R1 oe", {1'b0, pin_oe}, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_reserved();
    logic [7:0] d;
    wr(AS, 8'hFF); rd(AS, d); chk("R2 sel bit7", d, 8'h7F);
    wr(AS, 8'h00);
  endtask

  task automatic t_level();
    logic [7:0] d;
    pin_in[1] = 1'b1; settle();
    rd(AT, d); chk("R3 level high", d & 8'h02, 8'h02);
    rd(AT, d); chk("R3 no clear on read", d & 8'h02, 8'h02);
    pin_in[1] = 1'b0; settle();
    rd(AT, d); chk("R3 level low", d & 8'h02, 8'h00);
  endtask

  task automatic t_edge();
    logic [7:0] d;
    wr(AS, 8'h05);
    pin_in[2] = 1'b1; settle(); pin_in[2] = 1'b0; settle();
    rd(AT, d); chk("R4 latched after fall", d & 8'h04, 8'h04);
    rd(AT, d); chk("R4 cleared by read", d & 8'h04, 8'h00);
    chk("R6 unmasked edge no irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_coincide();
    logic [7:0] d;
    pin_in[0] = 1'b1; settle(); pin_in[0] = 1'b0; settle();
    @(negedge clk); pin_in[0] = 1'b1;
    @(negedge clk); @(negedge clk);
    bus_addr = AT; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
    chk("R5 first read", d & 8'h01, 8'h01);
    rd(AT, d); chk("R5 edge kept over clear", d & 8'h01, 8'h01);
    rd(AT, d); chk("R5 then cleared", d & 8'h01, 8'h00);
    pin_in[0] = 1'b0; settle();
  endtask

  task automatic t_irq_edge();
    logic [7:0] d;
    wr(AM, 8'h04);
    pin_in[2] = 1'b1; settle(); pin_in[2] = 1'b0; settle();
    chk("R7 irq set", {7'b0, irq}, 8'h01);
    rd(AI, d); chk("R7 irqstat", d, 8'h04);
    chk("R7 irq after irqstat read", {7'b0, irq}, 8'h01);
    rd(AT, d); chk("R6 masked edge latched", d & 8'h04, 8'h04);
    repeat (2) @(negedge clk);
    chk("R7 irq dropped", {7'b0, irq}, 8'h00);
    rd(AT, d); chk("R6 masked edge cleared", d & 8'h04, 8'h00);
  endtask

  task automatic t_irq_level();
    wr(AM, 8'h02);
    pin_in[1] = 1'b1; settle();
    chk("R8 irq high", {7'b0, irq}, 8'h01);
    pin_in[1] = 1'b0; settle();
    chk("R8 irq low", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_output();
    logic [7:0] d;
    wr(AD, 8'h30); wr(AS, 8'h15); wr(AM, 8'h20);
    wr(AT, 8'h18);
    chk("R9 oe", {1'b0, pin_oe}, 8'h30);
    chk("R9 pin_out", {1'b0, pin_out}, 8'h10);
    chk("R10 input pin_out untouched", {1'b0, pin_out} & 8'h08, 8'h00);
    rd(AT, d); chk("R9 readback", d & 8'h30, 8'h10);
    chk("R10 input stat untouched", d & 8'h08, 8'h00);
    pin_in[5] = 1'b1; pin_in[4] = 1'b0; settle();
    rd(AT, d); chk("R9 pin_in no effect", d & 8'h30, 8'h10);
    chk("R9 no irq from output", {7'b0, irq}, 8'h00);
    wr(AT, 8'h20);
    chk("R9 pin_out rewrite", {1'b0, pin_out}, 8'h20);
    pin_in[5] = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_reserved();
    t_level();
    t_edge();
    t_coincide();
    t_irq_edge();
    t_irq_level();
    t_output();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog R1 actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule